// File: doc/BRIEF.md
# Power-Good and RTC Power-Sense Reset Controller

This block turns two asynchronous board-level power signals into the internal reset and isolation controls of a single-chip PC core-logic device. The power-good input is both the general hardware reset and the power-down control. While it is low, the block holds the core in reset and isolates the core from the pads. It forces the nonessential inputs to fixed idle levels, turns off the global enable of the tristate pads, and holds the oscillator clock output low. When power-good returns, the core reset is released after a synchronizer delay and a fixed hold time.

The power-sense input is a separate reset domain for the real-time clock. When it drops, the block resets only the RTC control bits and closes the RTC interrupt gate. It also raises a sticky flag that marks the clock and calendar contents as untrustworthy. It does not touch the timekeeping counters or the CMOS RAM. Power-good never resets anything in this domain, and power-sense never resets the core. Both reset outputs assert at once with no clock, and both release synchronously.

Top module: `pwr_sense_ctrl`

## Requirements
- R1: While `pwr_good_in` is low, `core_rst` is 1. It goes to 1 as soon as `pwr_good_in` falls, with no clock edge needed.
- R2: After `pwr_good_in` rises, `core_rst` falls on exactly the SYNC_STAGES+HOLD_CYC-th rising clock edge (default 2+4 = 6). This keeps it high for at least 4 cycles after synchronized power-good is high.
- R3: While `core_rst` is 1, `ext_gated` equals the parameter IN_IDLE (default 8'h0F), whatever `ext_in` is. Otherwise `ext_gated` equals `ext_in`.
- R4: While `core_rst` is 1, `pad_oe` is 0 (pads tristated) and `osc_force_low` is 1. Otherwise `pad_oe` is 1 and `osc_force_low` is 0.
- R5: While `batt_sense_in` is low, `rtc_ctl_rst` is 1, with no clock edge needed. It falls on the SYNC_STAGES-th rising edge (default 2) after `batt_sense_in` rises.
- R6: `rtc_irq_en` goes to 0 as soon as `batt_sense_in` falls. It returns to 1 on the first rising edge after `rtc_ctl_rst` has fallen.
- R7: `rtc_inval` is set as soon as `batt_sense_in` falls, and it stays 1 after `batt_sense_in` rises again. It clears on a rising edge where `inval_clr` is 1 while both `rtc_ctl_rst` and `core_rst` are 0. A strobe at any other time is ignored.
- R8: `pwr_good_in` has no effect on `rtc_ctl_rst`, `rtc_irq_en` or `rtc_inval`.
- R9: `batt_sense_in` has no effect on `core_rst`, `pad_oe`, `osc_force_low` or `ext_gated`.
- R10: When `batt_sense_in` is pulsed low while `pwr_good_in` is low, `core_rst` and `rtc_ctl_rst` are both 1 together and every isolation control is in its safe state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| pwr_good_in | input | 1 | Asynchronous power-good; low means power down and hardware reset |
| batt_sense_in | input | 1 | Asynchronous RTC power sense; low means RTC supply was lost |
| ext_in | input | IN_W | Nonessential inputs from the pads |
| inval_clr | input | 1 | Software strobe that clears the RTC-invalid flag |
| ext_gated | output | IN_W | Inputs after gating to idle levels |
| core_rst | output | 1 | Core reset, active high |
| pad_oe | output | 1 | Global output enable of the tristate pads |
| osc_force_low | output | 1 | Forces the oscillator clock output steadily low |
| rtc_ctl_rst | output | 1 | Reset of the RTC control bits, active high |
| rtc_irq_en | output | 1 | RTC interrupt gate, 1 = open |
| rtc_inval | output | 1 | Sticky flag: RTC contents may be invalid |

## Verification
The bench drops each power input with no clock edge following and samples at once. A design that registered the asserting edge would leave the core running, or the RTC interrupt open, for a cycle or more. It counts the edges to each release and catches a hold counter or synchronizer that is off by one. It drops each domain while the other stays up, which exposes any cross-coupling: for example, power-good wiping the invalid flag, or power-sense resetting the core. It also sends the clear strobe while each reset is active, to catch a flag that clears before software could legally write it.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;
   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MIN_HOLD_CYC    = 4;

   // width of a counter that must reach the value n
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/pwrctl_sync.sv
module pwrctl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic async_ok,
   output logic sync_ok
);
   import pwrctl_pkg::*;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("pwrctl_sync: STAGES below minimum");
   end

   logic [STAGES-1:0] shreg;

   // asserting edge acts at once, release walks through the chain
   always_ff @(posedge clk or negedge async_ok) begin
      if (!async_ok) shreg <= '0;
      else           shreg <= {shreg[STAGES-2:0], 1'b1};
   end

   assign sync_ok = shreg[STAGES-1];

   // R5
   sync_release_chk: assert property (@(posedge clk) disable iff (!async_ok)
      $rose(sync_ok) |-> $past(async_ok));
endmodule

// File: rtl/pwrctl_hold.sv
module pwrctl_hold #(
   parameter int unsigned HOLD_CYC = 4
) (
   input  logic clk,
   input  logic arst_n,
   input  logic start,
   output logic rst_out
);
   import pwrctl_pkg::*;

   localparam int unsigned CW = cnt_width(HOLD_CYC);
   localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

   if (HOLD_CYC < MIN_HOLD_CYC) begin : g_bad_hold
      $error("pwrctl_hold: HOLD_CYC below minimum");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)            cnt <= '0;
      else if (!start)        cnt <= '0;
      else if (cnt != HOLD_V) cnt <= cnt + 1'b1;
   end

   assign rst_out = (cnt != HOLD_V);

   // R2
   core_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(rst_out) |-> (start && $past(start) && $past(start, 2) && $past(start, 3)));
endmodule

// File: rtl/pwrctl_iso.sv
module pwrctl_iso #(
   parameter int unsigned IN_W = 8,
   parameter logic [IN_W-1:0] IN_IDLE = '0
) (
   input  logic            hold,
   input  logic [IN_W-1:0] ext_in,
   output logic [IN_W-1:0] ext_gated,
   output logic            pad_oe,
   output logic            osc_force_low
);
   if (IN_W < 1) begin : g_bad_width
      $error("pwrctl_iso: IN_W must be at least 1");
   end

   // each bit is clamped toward its own idle level
   for (genvar b = 0; b < IN_W; b++) begin : g_bit
      if (IN_IDLE[b]) begin : g_idle_hi
         assign ext_gated[b] = ext_in[b] | hold;
      end else begin : g_idle_lo
         assign ext_gated[b] = ext_in[b] & ~hold;
      end
   end

   assign pad_oe        = ~hold;
   assign osc_force_low = hold;
endmodule

// File: rtl/pwrctl_rtc.sv
module pwrctl_rtc #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic sense_in,
   input  logic clr_req,
   input  logic core_rst,
   output logic ctl_rst,
   output logic irq_en,
   output logic inval
);
   logic sense_sync;
   logic clr_ok;

   pwrctl_sync #(.STAGES(STAGES)) u_sense_sync (
      .clk      (clk),
      .async_ok (sense_in),
      .sync_ok  (sense_sync)
   );

   assign ctl_rst = ~sense_sync;
   assign clr_ok  = clr_req & sense_sync & ~core_rst;

   always_ff @(posedge clk or negedge sense_in) begin
      if (!sense_in) irq_en <= 1'b0;
      else           irq_en <= sense_sync;
   end

   always_ff @(posedge clk or negedge sense_in) begin
      if (!sense_in)   inval <= 1'b1;
      else if (clr_ok) inval <= 1'b0;
   end

   // R6
   irq_gate_chk: assert property (@(posedge clk) disable iff (!sense_in)
      irq_en |-> !ctl_rst);
   // R7
   inval_clear_chk: assert property (@(posedge clk) disable iff (!sense_in)
      $fell(inval) |-> ($past(clr_req) && !$past(core_rst) && !$past(ctl_rst)));
endmodule

// File: rtl/pwr_sense_ctrl.sv
module pwr_sense_ctrl #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYC    = 4,
   parameter int unsigned IN_W        = 8,
   parameter logic [IN_W-1:0] IN_IDLE = 8'h0F
) (
   input  logic            clk,
   input  logic            pwr_good_in,
   input  logic            batt_sense_in,
   input  logic [IN_W-1:0] ext_in,
   input  logic            inval_clr,
   output logic [IN_W-1:0] ext_gated,
   output logic            core_rst,
   output logic            pad_oe,
   output logic            osc_force_low,
   output logic            rtc_ctl_rst,
   output logic            rtc_irq_en,
   output logic            rtc_inval
);
   logic pg_sync;

   pwrctl_sync #(.STAGES(SYNC_STAGES)) u_pg_sync (
      .clk      (clk),
      .async_ok (pwr_good_in),
      .sync_ok  (pg_sync)
   );

   pwrctl_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk     (clk),
      .arst_n  (pwr_good_in),
      .start   (pg_sync),
      .rst_out (core_rst)
   );

   pwrctl_iso #(.IN_W(IN_W), .IN_IDLE(IN_IDLE)) u_iso (
      .hold          (core_rst),
      .ext_in        (ext_in),
      .ext_gated     (ext_gated),
      .pad_oe        (pad_oe),
      .osc_force_low (osc_force_low)
   );

   pwrctl_rtc #(.STAGES(SYNC_STAGES)) u_rtc (
      .clk      (clk),
      .sense_in (batt_sense_in),
      .clr_req  (inval_clr),
      .core_rst (core_rst),
      .ctl_rst  (rtc_ctl_rst),
      .irq_en   (rtc_irq_en),
      .inval    (rtc_inval)
   );

   always @(posedge clk) begin
      // R1
      if (!pwr_good_in) pg_low_rst_chk: assert (core_rst);
      // R3
      if (core_rst) in_gate_chk: assert (ext_gated == IN_IDLE);
      // R4
      if (core_rst) pad_safe_chk: assert (!pad_oe && osc_force_low);
   end
endmodule

// File: tb/pwr_sense_ctrl_test.sv
module pwr_sense_ctrl_test;
   localparam logic [7:0] IDLE = 8'h0F;

   logic       clk = 1'b0;
   logic       pwr_good_in, batt_sense_in, inval_clr;
   logic [7:0] ext_in, ext_gated;
   logic       core_rst, pad_oe, osc_force_low, rtc_ctl_rst, rtc_irq_en, rtc_inval;
   int         vectors = 0;
   int         miscompares = 0;

   always #4 clk = ~clk;

   pwr_sense_ctrl uut (
      .clk(clk), .pwr_good_in(pwr_good_in), .batt_sense_in(batt_sense_in),
      .ext_in(ext_in), .inval_clr(inval_clr), .ext_gated(ext_gated),
      .core_rst(core_rst), .pad_oe(pad_oe), .osc_force_low(osc_force_low),
      .rtc_ctl_rst(rtc_ctl_rst), .rtc_irq_en(rtc_irq_en), .rtc_inval(rtc_inval)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe_clr();
      inval_clr = 1'b1;
      tick(1);
      inval_clr = 1'b0;
   endtask

   task automatic t_reset_state();
      check("R10 core_rst", core_rst, 1);
      check("R10 rtc_ctl_rst", rtc_ctl_rst, 1);
      check("R1 core_rst while pg low", core_rst, 1);
      check("R3 ext_gated idle", ext_gated, IDLE);
      check("R4 pad_oe off", pad_oe, 0);
      check("R4 osc forced low", osc_force_low, 1);
      check("R6 irq gate closed", rtc_irq_en, 0);
      check("R7 inval set", rtc_inval, 1);
   endtask

   task automatic t_sense_release();
      batt_sense_in = 1'b1;
      tick(1);
      check("R5 ctl rst held 1 edge", rtc_ctl_rst, 1);
      tick(1);
      check("R5 ctl rst released", rtc_ctl_rst, 0);
      check("R6 irq still closed", rtc_irq_en, 0);
      tick(1);
      check("R6 irq reopened", rtc_irq_en, 1);
      check("R7 inval sticky", rtc_inval, 1);
      check("R9 core_rst unaffected", core_rst, 1);
   endtask

   task automatic t_clr_in_core_reset();
      strobe_clr();
      check("R7 clr ignored in core reset", rtc_inval, 1);
   endtask

   task automatic t_pg_release();
      pwr_good_in = 1'b1;
      tick(5);
      check("R2 core_rst held at edge 5", core_rst, 1);
      tick(1);
      check("R2 core_rst released at edge 6", core_rst, 0);
      check("R4 pad_oe on", pad_oe, 1);
      check("R4 osc released", osc_force_low, 0);
   endtask

   task automatic t_input_pass();
      logic [7:0] pats [3] = '{8'hA5, 8'h3C, 8'hF0};
      for (int i = 0; i < 3; i++) begin
         ext_in = pats[i];
         #1;
         check("R3 ext passthrough", ext_gated, pats[i]);
      end
   endtask

   task automatic t_inval_clear();
      strobe_clr();
      check("R7 inval cleared", rtc_inval, 0);
   endtask

   task automatic t_sense_drop_core_kept();
      batt_sense_in = 1'b0;
      #1;
      check("R5 ctl rst immediate", rtc_ctl_rst, 1);
      check("R6 irq closed immediate", rtc_irq_en, 0);
      check("R7 inval set immediate", rtc_inval, 1);
      check("R9 core_rst stays 0", core_rst, 0);
      check("R9 pad_oe stays 1", pad_oe, 1);
      check("R9 ext_gated passes", ext_gated, ext_in);
      strobe_clr();
      check("R7 clr ignored in rtc reset", rtc_inval, 1);
      batt_sense_in = 1'b1;
      tick(3);
      check("R6 irq reopened", rtc_irq_en, 1);
      check("R9 core_rst after sense", core_rst, 0);
      strobe_clr();
      check("R7 inval cleared again", rtc_inval, 0);
   endtask

   task automatic t_pg_drop_rtc_kept();
      pwr_good_in = 1'b0;
      #1;
      check("R1 core_rst immediate", core_rst, 1);
      check("R3 ext gated on drop", ext_gated, IDLE);
      check("R4 osc forced on drop", osc_force_low, 1);
      check("R8 ctl rst untouched", rtc_ctl_rst, 0);
      check("R8 irq untouched", rtc_irq_en, 1);
      check("R8 inval untouched", rtc_inval, 0);
      tick(3);
      check("R8 ctl rst later", rtc_ctl_rst, 0);
      check("R8 irq later", rtc_irq_en, 1);
      check("R8 inval later", rtc_inval, 0);
   endtask

   task automatic t_full_reset();
      batt_sense_in = 1'b0;
      #1;
      check("R10 core_rst", core_rst, 1);
      check("R10 ctl rst", rtc_ctl_rst, 1);
      check("R10 pad_oe off", pad_oe, 0);
      check("R10 inval set", rtc_inval, 1);
      tick(2);
      batt_sense_in = 1'b1;
      pwr_good_in   = 1'b1;
      tick(6);
      check("R2 core_rst released", core_rst, 0);
      check("R6 irq open", rtc_irq_en, 1);
      check("R7 inval still set", rtc_inval, 1);
   endtask

   initial begin
      #800000;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      pwr_good_in   = 1'b0;
      batt_sense_in = 1'b0;
      inval_clr     = 1'b0;
      ext_in        = 8'h00;
      tick(3);
      t_reset_state();
      t_sense_release();
      t_clr_in_core_reset();
      t_pg_release();
      t_input_pass();
      t_inval_clear();
      t_sense_drop_core_kept();
      t_pg_drop_rtc_kept();
      t_full_reset();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule